// File: doc/BRIEF.md
# Strided Block Copy Engine

This engine copies a byte range from one memory region to another in 16-byte granules. Software supplies a source byte address, a destination byte address, a total byte count, and for each side a line width and an inter-line gap. Both the width and the gap are counted in granules. Either side can therefore be strided: after a side has moved one line's worth of granules, its pointer jumps over the gap and a new line starts. The read side and the write side keep their own line counters, so a source with one stride pattern can be repacked into a destination with a different one.

A one-cycle `start` pulse latches the configuration. The engine issues granule read requests on a valid/ready request channel and accepts the returned data in order on a valid/ready data channel. It forwards each granule straight to the write channel, with the write address taken from the destination walker. When the last granule has been written, `doneIrq` pulses. An invalid configuration puts the engine into a halted state. In that state the error flag is set, no memory traffic is issued and no interrupt is raised. Only a reset leaves this state.

Top module: `strided_copy_dma`

## Requirements
- R1: The byte count is rounded down to a whole number of 16-byte granules. Exactly floor(size/16) granules are read and written.
- R2: If the rounded count is zero, the engine enters a halted state. In that state `errFlag`=1 and `busy`=1, no read or write request is issued, no interrupt is raised, and any later `start` is ignored until reset.
- R3: A side whose gap is nonzero and whose width field is zero has a zero effective line width. This leads to the same halted state as R2, whether it is the input side or the output side.
- R4: A side whose gap field is zero is contiguous. Its line width is taken as the whole transfer, whatever its width field holds, including zero.
- R5: Read addresses start at `srcAddr` and advance by 16 for each granule. After every `inWidth` granules, an extra `inGap`*16 bytes are added.
- R6: Write addresses follow the same rule from `dstAddr` with `outWidth`/`outGap`, independently of the input side.
- R7: The granules written carry the data read, in the same order: the k-th write carries the k-th read's data.
- R8: `doneIrq` is high for exactly one cycle after the final write. In that cycle `busy` is already low.
- R9: When every ready input and data valid input is held high, N granules complete within N+6 cycles of `start`.
- R10: While `rdReqValid` is high and `rdReqReady` is low, the request stays valid and its address stays unchanged. Random back-pressure on every channel does not change the address or data sequences.
- R11: A `start` pulse during a running copy is ignored. The running copy completes with its own configuration and raises only one interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, latches the configuration |
| srcAddr | input | ADDR_W | Source byte address |
| dstAddr | input | ADDR_W | Destination byte address |
| sizeBytes | input | SIZE_W | Total byte count |
| inWidth | input | FLD_W | Source line width in granules |
| inGap | input | FLD_W | Source gap in granules |
| outWidth | input | FLD_W | Destination line width in granules |
| outGap | input | FLD_W | Destination gap in granules |
| busy | output | 1 | Copy running or engine halted |
| errFlag | output | 1 | Sticky configuration error |
| doneIrq | output | 1 | Completion pulse |
| rdReqValid | output | 1 | Read request valid |
| rdReqReady | input | 1 | Read request accepted |
| rdReqAddr | output | ADDR_W | Read granule address |
| rdDataValid | input | 1 | Read data valid |
| rdDataReady | output | 1 | Read data accepted |
| rdData | input | 128 | Read data granule |
| wrValid | output | 1 | Write valid |
| wrReady | input | 1 | Write accepted |
| wrAddr | output | ADDR_W | Write granule address |
| wrData | output | 128 | Write data granule |

## Verification
Fully contiguous copies use zero gaps and zero width fields, with a byte count that is not a multiple of 16. They separate the rounding rule and the gap-zero rule from the stride logic. A strided-source copy and a strided-destination copy each hold the other side contiguous, so a fault in one walker cannot hide behind the other. A copy with different strides on both sides, run under random back-pressure, shows whether the two line counters are truly independent of each other and of stalls. A stall-free copy measures throughput. Separate error cases for zero size, zero input width and zero output width confirm the halt with no traffic and no interrupt.

// File: rtl/strided_copy_pkg.sv
package strided_copy_pkg;
  localparam int GRAN_BYTES = 16;
  localparam int GRAN_SHIFT = 4;
  localparam int DATA_W     = 128;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HALT = 2'd2
  } ctrlState_e;

  // control -> datapath
  typedef struct packed {
    logic load;
    logic run;
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic cfgBad;
    logic wrEmpty;
  } dpStatus_t;
endpackage

// File: rtl/strided_copy_walker.sv
// Address generator for one side: granule pointer, line countdown, total countdown.
module strided_copy_walker
  import strided_copy_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 20,
  parameter int FLD_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [CNT_W-1:0]  lineGran,
  input  logic [CNT_W-1:0]  totalGran,
  input  logic [FLD_W-1:0]  gapGran,
  output logic [ADDR_W-1:0] curAddr,
  output logic              empty
);
  localparam logic [ADDR_W-1:0] STEP_BYTES = ADDR_W'(GRAN_BYTES);

  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] skipBytes;
  logic [CNT_W-1:0]  lineLen;
  logic [CNT_W-1:0]  lineLeft;
  logic [CNT_W-1:0]  totalLeft;
  logic              lineEnd;
  logic [ADDR_W-1:0] nextPtr;

  assign lineEnd = (lineLeft == CNT_W'(1));
  assign nextPtr = ptr + STEP_BYTES + (lineEnd ? skipBytes : '0);
  assign curAddr = ptr;
  assign empty   = (totalLeft == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr       <= '0;
      skipBytes <= '0;
      lineLen   <= '0;
      lineLeft  <= '0;
      totalLeft <= '0;
    end else if (load) begin
      ptr       <= baseAddr;
      skipBytes <= ADDR_W'(gapGran) << GRAN_SHIFT;
      lineLen   <= lineGran;
      lineLeft  <= lineGran;
      totalLeft <= totalGran;
    end else if (step && !empty) begin
      ptr       <= nextPtr;
      lineLeft  <= lineEnd ? lineLen : lineLeft - CNT_W'(1);
      totalLeft <= totalLeft - CNT_W'(1);
    end
  end
endmodule

// File: rtl/strided_copy_datapath.sv
module strided_copy_datapath
  import strided_copy_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 24,
  parameter int FLD_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] srcAddr,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [SIZE_W-1:0] sizeBytes,
  input  logic [FLD_W-1:0]  inWidth,
  input  logic [FLD_W-1:0]  inGap,
  input  logic [FLD_W-1:0]  outWidth,
  input  logic [FLD_W-1:0]  outGap,
  output logic              rdReqValid,
  input  logic              rdReqReady,
  output logic [ADDR_W-1:0] rdReqAddr,
  input  logic              rdDataValid,
  output logic              rdDataReady,
  input  logic [DATA_W-1:0] rdData,
  output logic              wrValid,
  input  logic              wrReady,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output dpStatus_t         status
);
  localparam int CNT_W = SIZE_W - GRAN_SHIFT;
  localparam int SIDES = 2;  // 0: read side, 1: write side

  logic [CNT_W-1:0]  totalGran;
  logic [CNT_W-1:0]  effLine [SIDES];
  logic [FLD_W-1:0]  gapSel  [SIDES];
  logic [FLD_W-1:0]  widSel  [SIDES];
  logic [ADDR_W-1:0] baseSel [SIDES];
  logic              stepSel [SIDES];
  logic [ADDR_W-1:0] addrOut [SIDES];
  logic              emptyOut[SIDES];
  logic              rdFire;
  logic              wrFire;

  assign totalGran = CNT_W'(sizeBytes >> GRAN_SHIFT);

  assign gapSel[0]  = inGap;
  assign gapSel[1]  = outGap;
  assign widSel[0]  = inWidth;
  assign widSel[1]  = outWidth;
  assign baseSel[0] = srcAddr;
  assign baseSel[1] = dstAddr;
  assign stepSel[0] = rdFire;
  assign stepSel[1] = wrFire;

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    // a side with no gap is one line spanning the whole transfer
    assign effLine[s] = (gapSel[s] == '0) ? totalGran : CNT_W'(widSel[s]);

    strided_copy_walker #(
      .ADDR_W(ADDR_W),
      .CNT_W (CNT_W),
      .FLD_W (FLD_W)
    ) u_walker (
      .clk      (clk),
      .rstN     (rstN),
      .load     (strobe.load),
      .step     (stepSel[s]),
      .baseAddr (baseSel[s]),
      .lineGran (effLine[s]),
      .totalGran(totalGran),
      .gapGran  (gapSel[s]),
      .curAddr  (addrOut[s]),
      .empty    (emptyOut[s])
    );
  end

  assign rdReqValid  = strobe.run && !emptyOut[0];
  assign rdReqAddr   = addrOut[0];
  assign rdFire      = rdReqValid && rdReqReady;

  assign wrValid     = strobe.run && rdDataValid;
  assign rdDataReady = strobe.run && wrReady;
  assign wrAddr      = addrOut[1];
  assign wrData      = rdData;
  assign wrFire      = wrValid && wrReady;

  assign status.cfgBad  = (totalGran == '0) || (effLine[0] == '0) || (effLine[1] == '0);
  assign status.wrEmpty = emptyOut[1];
endmodule

// File: rtl/strided_copy_ctrl.sv
module strided_copy_ctrl
  import strided_copy_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        errFlag,
  output logic        doneIrq
);
  ctrlState_e state;
  ctrlState_e stateNext;
  logic       finish;

  assign finish = (state == ST_RUN) && status.wrEmpty;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (start) stateNext = status.cfgBad ? ST_HALT : ST_RUN;
      ST_RUN:  if (finish) stateNext = ST_IDLE;
      ST_HALT: stateNext = ST_HALT;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      doneIrq <= 1'b0;
    end else begin
      state   <= stateNext;
      doneIrq <= finish;
    end
  end

  assign strobe.load = (state == ST_IDLE) && start && !status.cfgBad;
  assign strobe.run  = (state == ST_RUN);
  assign busy        = (state != ST_IDLE);
  assign errFlag     = (state == ST_HALT);
endmodule

// File: rtl/strided_copy_dma.sv
module strided_copy_dma
  import strided_copy_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 24,
  parameter int FLD_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] srcAddr,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [SIZE_W-1:0] sizeBytes,
  input  logic [FLD_W-1:0]  inWidth,
  input  logic [FLD_W-1:0]  inGap,
  input  logic [FLD_W-1:0]  outWidth,
  input  logic [FLD_W-1:0]  outGap,
  output logic              busy,
  output logic              errFlag,
  output logic              doneIrq,
  output logic              rdReqValid,
  input  logic              rdReqReady,
  output logic [ADDR_W-1:0] rdReqAddr,
  input  logic              rdDataValid,
  output logic              rdDataReady,
  input  logic [127:0]      rdData,
  output logic              wrValid,
  input  logic              wrReady,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [127:0]      wrData
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;

  strided_copy_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .status (status),
    .strobe (strobe),
    .busy   (busy),
    .errFlag(errFlag),
    .doneIrq(doneIrq)
  );

  strided_copy_datapath #(
    .ADDR_W(ADDR_W),
    .SIZE_W(SIZE_W),
    .FLD_W (FLD_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .srcAddr    (srcAddr),
    .dstAddr    (dstAddr),
    .sizeBytes  (sizeBytes),
    .inWidth    (inWidth),
    .inGap      (inGap),
    .outWidth   (outWidth),
    .outGap     (outGap),
    .rdReqValid (rdReqValid),
    .rdReqReady (rdReqReady),
    .rdReqAddr  (rdReqAddr),
    .rdDataValid(rdDataValid),
    .rdDataReady(rdDataReady),
    .rdData     (rdData),
    .wrValid    (wrValid),
    .wrReady    (wrReady),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .status     (status)
  );
endmodule

// File: rtl/strided_copy_dma_checker.sv
module strided_copy_dma_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              errFlag,
  input logic              doneIrq,
  input logic              rdReqValid,
  input logic              rdReqReady,
  input logic [ADDR_W-1:0] rdReqAddr,
  input logic              wrValid
);
  // R2/R3: halted state never leaves without reset
  a_r2_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R2/R3: no memory traffic when idle or halted
  a_r2_no_traffic: assert property (@(posedge clk) disable iff (!rstN)
    (!busy || errFlag) |-> (!rdReqValid && !wrValid));

  // R8: completion is a single-cycle pulse
  a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> !doneIrq);

  // R8: busy already low, never with an error
  a_r8_irq_idle: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> (!busy && !errFlag));

  // R10: a stalled request holds valid and address
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rdReqValid && !rdReqReady) |=> (rdReqValid && $stable(rdReqAddr)));
endmodule

bind strided_copy_dma strided_copy_dma_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .errFlag   (errFlag),
  .doneIrq   (doneIrq),
  .rdReqValid(rdReqValid),
  .rdReqReady(rdReqReady),
  .rdReqAddr (rdReqAddr),
  .wrValid   (wrValid)
);

// File: tb/strided_copy_dma_test.sv
module strided_copy_dma_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [31:0]  srcAddr = '0, dstAddr = '0;
  logic [23:0]  sizeBytes = '0;
  logic [15:0]  inWidth = '0, inGap = '0, outWidth = '0, outGap = '0;
  logic         busy, errFlag, doneIrq;
  logic         rdReqValid, rdReqReady, rdDataValid, rdDataReady;
  logic [31:0]  rdReqAddr, wrAddr;
  logic [127:0] rdData, wrData;
  logic         wrValid, wrReady;

  int checks = 0;
  int errors = 0;
  int wdCount = 0;

  // memory model state
  logic         stall = 1'b0;
  logic [15:0]  lfsr;
  logic [31:0]  pend [0:255];
  logic [7:0]   head, tail;
  logic [31:0]  rdLog [0:255];
  logic [31:0]  wrALog[0:255];
  logic [127:0] wrDLog[0:255];
  int           nRd, nWr, nIrq;

  always #2 clk = ~clk;

  strided_copy_dma uut (
    .clk(clk), .rstN(rstN), .start(start),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .sizeBytes(sizeBytes),
    .inWidth(inWidth), .inGap(inGap), .outWidth(outWidth), .outGap(outGap),
    .busy(busy), .errFlag(errFlag), .doneIrq(doneIrq),
    .rdReqValid(rdReqValid), .rdReqReady(rdReqReady), .rdReqAddr(rdReqAddr),
    .rdDataValid(rdDataValid), .rdDataReady(rdDataReady), .rdData(rdData),
    .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr), .wrData(wrData)
  );

  function automatic logic [127:0] pat(logic [31:0] a);
    return {a, ~a, a ^ 32'h5A5A_C3C3, a + 32'd7};
  endfunction

  assign rdReqReady  = stall ? lfsr[0] : 1'b1;
  assign wrReady     = stall ? (lfsr[2] | lfsr[7]) : 1'b1;
  assign rdDataValid = (head != tail) && (stall ? lfsr[4] : 1'b1);
  assign rdData      = pat(pend[head]);

  always @(posedge clk) begin
    if (!rstN) begin
      head <= '0; tail <= '0; nRd <= 0; nWr <= 0; nIrq <= 0; lfsr <= 16'hACE1;
    end else begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (rdReqValid && rdReqReady) begin
        pend[tail] <= rdReqAddr;
        rdLog[nRd[7:0]] <= rdReqAddr;
        tail <= tail + 8'd1;
        nRd <= nRd + 1;
      end
      if (rdDataValid && rdDataReady) head <= head + 8'd1;
      if (wrValid && wrReady) begin
        wrALog[nWr[7:0]] <= wrAddr;
        wrDLog[nWr[7:0]] <= wrData;
        nWr <= nWr + 1;
      end
      if (doneIrq) nIrq <= nIrq + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expAddr(logic [31:0] base, int effW, int gap, int k);
    logic [31:0] p = base;
    int left = effW;
    for (int i = 0; i < k; i++) begin
      p += 32'd16;
      left--;
      if (left == 0) begin
        p += 32'(gap * 16);
        left = effW;
      end
    end
    return p;
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; start = 1'b0; stall = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic launch(input logic [31:0] s, input logic [31:0] d, input int sz,
                        input int iw, input int ig, input int ow, input int og);
    srcAddr = s; dstAddr = d; sizeBytes = 24'(sz);
    inWidth = 16'(iw); inGap = 16'(ig); outWidth = 16'(ow); outGap = 16'(og);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(input string req, output int cyc);
    cyc = 1;
    while (!doneIrq && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    chk(doneIrq == 1'b1, req, "completion pulse seen", 128'(doneIrq), 128'd1);
    chk(busy == 1'b0, "R8", "busy low with pulse", 128'(busy), 128'd0);
    @(negedge clk);
    chk(doneIrq == 1'b0, "R8", "pulse one cycle", 128'(doneIrq), 128'd0);
  endtask

  task automatic verifyLogs(input logic [31:0] s, input logic [31:0] d, input int sz,
                            input int iw, input int ig, input int ow, input int og,
                            input string req);
    int tot = sz / 16;
    int effI = (ig == 0) ? tot : iw;
    int effO = (og == 0) ? tot : ow;
    int badA = 0, badR = 0, badD = 0;
    logic [31:0] firstBadAct = '0, firstBadExp = '0;
    chk(nWr == tot, "R1", {req, " write count"}, 128'(nWr), 128'(tot));
    chk(nRd == tot, "R1", {req, " read count"}, 128'(nRd), 128'(tot));
    for (int k = 0; k < tot && k < 256; k++) begin
      logic [31:0] es = expAddr(s, effI, ig, k);
      logic [31:0] ed = expAddr(d, effO, og, k);
      if (rdLog[k] != es) begin
        if (badR == 0) begin firstBadAct = rdLog[k]; firstBadExp = es; end
        badR++;
      end
      if (wrALog[k] != ed) begin
        if (badA == 0 && badR == 0) begin firstBadAct = wrALog[k]; firstBadExp = ed; end
        badA++;
      end
      if (wrDLog[k] != pat(es)) badD++;
    end
    chk(badR == 0, "R5", {req, " read address sequence"}, 128'(firstBadAct), 128'(firstBadExp));
    chk(badA == 0, "R6", {req, " write address sequence"}, 128'(firstBadAct), 128'(firstBadExp));
    chk(badD == 0, "R7", {req, " write data sequence"}, 128'(badD), 128'd0);
    chk(nIrq == 1, "R8", {req, " interrupt count"}, 128'(nIrq), 128'd1);
  endtask

  task automatic runCopy(input logic [31:0] s, input logic [31:0] d, input int sz,
                         input int iw, input int ig, input int ow, input int og,
                         input bit st, input string req, output int cyc);
    doReset();
    stall = st;
    launch(s, d, sz, iw, ig, ow, og);
    waitDone(req, cyc);
    @(negedge clk);
    verifyLogs(s, d, sz, iw, ig, ow, og, req);
  endtask

  task automatic testReset();
    doReset();
    chk(busy == 1'b0, "R8", "reset busy", 128'(busy), 128'd0);
    chk(errFlag == 1'b0, "R2", "reset errFlag", 128'(errFlag), 128'd0);
    chk(doneIrq == 1'b0, "R8", "reset doneIrq", 128'(doneIrq), 128'd0);
    chk(!rdReqValid && !wrValid, "R2", "reset no traffic",
        128'({rdReqValid, wrValid}), 128'd0);
  endtask

  // R1 R4: contiguous both sides, width fields zero, size not granule aligned
  task automatic testContig();
    int cyc;
    runCopy(32'h0000_1000, 32'h0000_8000, 16 * 5 + 7, 0, 0, 0, 0, 1'b0, "R4", cyc);
  endtask

  // R5: strided source, contiguous destination
  task automatic testSrcStride();
    int cyc;
    runCopy(32'h0000_2000, 32'h0000_9000, 16 * 10, 2, 3, 5, 0, 1'b0, "R5", cyc);
  endtask

  // R6: strided destination, contiguous source
  task automatic testDstStride();
    int cyc;
    runCopy(32'h0000_3000, 32'h0000_A000, 16 * 9, 4, 0, 3, 1, 1'b0, "R6", cyc);
  endtask

  // R10: independent strides on both sides with random back-pressure
  task automatic testBothStall();
    int cyc;
    runCopy(32'h0000_4000, 32'h0000_B000, 16 * 11 + 15, 3, 1, 2, 2, 1'b1, "R10", cyc);
  endtask

  // R9: throughput with no stalls
  task automatic testThroughput();
    int cyc;
    runCopy(32'h0000_5000, 32'h0000_C000, 16 * 32, 0, 0, 0, 0, 1'b0, "R9", cyc);
    chk(cyc <= 32 + 6, "R9", "cycles for 32 granules", 128'(cyc), 128'd38);
  endtask

  // R11: start while busy is ignored
  task automatic testBusyStart();
    int cyc;
    doReset();
    stall = 1'b1;
    launch(32'h0000_6000, 32'h0000_D000, 16 * 16, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    launch(32'h0000_7000, 32'h0000_E000, 16 * 40, 1, 1, 1, 1);
    waitDone("R11", cyc);
    repeat (10) @(negedge clk);
    verifyLogs(32'h0000_6000, 32'h0000_D000, 16 * 16, 0, 0, 0, 0, "R11");
    chk(busy == 1'b0, "R11", "idle after single copy", 128'(busy), 128'd0);
  endtask

  // R2 R3: error configurations halt the engine
  task automatic errCase(input int sz, input int iw, input int ig,
                         input int ow, input int og, input string req);
    doReset();
    launch(32'h0000_1000, 32'h0000_2000, sz, iw, ig, ow, og);
    repeat (20) @(negedge clk);
    chk(errFlag == 1'b1, req, "error flag", 128'(errFlag), 128'd1);
    chk(busy == 1'b1, req, "hung busy", 128'(busy), 128'd1);
    chk(nRd == 0 && nWr == 0, req, "no traffic", 128'(nRd + nWr), 128'd0);
    chk(nIrq == 0, req, "no interrupt", 128'(nIrq), 128'd0);
    launch(32'h0000_1000, 32'h0000_2000, 16 * 4, 0, 0, 0, 0);
    repeat (20) @(negedge clk);
    chk(errFlag == 1'b1 && nRd == 0 && nIrq == 0, "R2", {req, " restart ignored"},
        128'({errFlag, 8'(nRd), 8'(nIrq)}), 128'h10000);
  endtask

  initial begin
    testReset();
    testContig();
    testSrcStride();
    testDstStride();
    testBothStall();
    testThroughput();
    testBusyStart();
    errCase(15, 0, 0, 0, 0, "R2");
    errCase(16 * 8, 0, 2, 0, 0, "R3");
    errCase(16 * 8, 0, 0, 0, 1, "R3");
    doReset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      wdCount++;
      if (wdCount > 150000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", wdCount);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end
endmodule